// File: doc/BRIEF.md
# Guarded Page Table Walker

This block resolves a virtual page number to a physical frame number. The page table is a multi-level tree in which single-path chains are compressed. A translation request names the key to resolve, the base address of the root node and the log2 entry count of that node. The walker then reads one node entry per level from memory. At every level the top bits of the key that have not yet been consumed select an entry in the current node. Each entry stores a guard of variable length, and the guard must equal the key bits that come right after the index. One entry can therefore skip address bits that a plain radix tree would spend a whole level on.

A match on a non-leaf entry moves the walk to the next node, whose base and size the entry gives. A leaf entry returns its frame number. The walk faults on a guard mismatch, an invalid entry, a key that is not consumed exactly, or a walk deeper than the level limit. The block sits behind a TLB: it takes one request at a time and reports each result with a one-cycle done pulse. Toward memory it has a read port with one read outstanding and any latency.

Top module: `gpt_walker`

## Requirements
- R1: Out of reset `req_ready` is 1, `rsp_done` is 0 and `mem_req_valid` is 0. A request is taken in a cycle where `req_valid` and `req_ready` are both 1, and `req_ready` stays 0 until the walk ends.
- R2: Each node entry is a 64-bit word laid out as follows. Bit 0 is the leaf flag and bit 1 the valid flag. Bits 7:3 hold the guard length g. Bits 11:8 hold the log2 size of the next node. Bits 12 and up, KEY_W bits wide, hold the guard. Bits 63:32 hold the next node base, or the frame number for a leaf. The first read goes to the root base plus the top s bits of the key times 32, where s is the root size.
- R3: Each later read goes to the base of the current node plus 32 times the index. The index is the next s bits of the key that follow everything consumed so far.
- R4: The g key bits right after the index are compared with the low g bits of the entry's guard. A mismatch ends the walk with a fault.
- R5: A leaf must consume exactly the remaining key, so that s + g equals the bits left. A non-leaf must leave bits over, so that s + g is less than the bits left, and it must name a next size of at least 1. Either rule broken gives a fault.
- R6: A valid leaf whose guard matches and that meets R5 returns the low PFN_W bits of its pointer field as the frame number, with the fault flag at 0.
- R7: An entry whose valid bit is 0 gives a fault.
- R8: A non-leaf entry fetched as the MAX_DEPTH-th read of a walk gives a fault.
- R9: `mem_req_valid` and `mem_addr` stay steady until `mem_req_ready` takes the read. No new read is issued before `mem_rsp_valid` returns the data, however many cycles that takes.
- R10: `rsp_done` lasts exactly one cycle per walk, and `rsp_pfn` is 0 whenever `rsp_fault` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_vpn | input | KEY_W | Key to resolve |
| req_root | input | AW | Root node base address |
| req_root_size | input | SZ_W | log2 of root node entry count |
| rsp_done | output | 1 | One-cycle result strobe |
| rsp_fault | output | 1 | Walk ended in a fault |
| rsp_pfn | output | PFN_W | Resulting frame number |
| mem_req_valid | output | 1 | Read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_addr | output | AW | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 64 | Entry word |

## Verification
The assertions assume that memory returns exactly one `mem_rsp_valid` pulse per accepted read, and only while the walker is waiting for it. They also assume that a root size is nonzero and no larger than KEY_W. The bench model answers each taken read once, after a latency that varies, and it withholds `mem_req_ready` for changing numbers of cycles to stretch the hold phase. A small table with leaves at several depths is walked for every 10-bit key. This covers guard hits and misses at each level, an invalid slot, a leaf that consumes the key short of its end, and a self-loop that trips the depth limit.

// File: rtl/gpt_walker.sv
module gpt_walker #(
  parameter int KEY_W     = 20,
  parameter int AW        = 32,
  parameter int PFN_W     = 20,
  parameter int SZ_W      = 4,
  parameter int MAX_DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [KEY_W-1:0] req_vpn,
  input  logic [AW-1:0]    req_root,
  input  logic [SZ_W-1:0]  req_root_size,
  output logic             rsp_done,
  output logic             rsp_fault,
  output logic [PFN_W-1:0] rsp_pfn,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [AW-1:0]    mem_addr,
  input  logic             mem_rsp_valid,
  input  logic [63:0]      mem_rsp_data
);
  localparam int CW = 7;
  localparam int DW = $clog2(MAX_DEPTH + 1);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} st_t;

  st_t              state;
  logic [KEY_W-1:0] key;
  logic [CW-1:0]    rem;
  logic [SZ_W-1:0]  size;
  logic [AW-1:0]    base;
  logic [DW-1:0]    depth;

  logic             e_leaf, e_valid;
  logic [4:0]       e_glen;
  logic [SZ_W-1:0]  e_nsize;
  logic [KEY_W-1:0] e_guard, kshift, gbits, gmask, idx;
  logic [AW-1:0]    e_ptr;
  logic [CW-1:0]    used;
  logic             gmatch, bad;
  logic             unused_bits;

  assign e_leaf      = mem_rsp_data[0];
  assign e_valid     = mem_rsp_data[1];
  assign unused_bits = mem_rsp_data[2];
  assign e_glen      = mem_rsp_data[7:3];
  assign e_nsize     = mem_rsp_data[8 +: SZ_W];
  assign e_guard     = mem_rsp_data[12 +: KEY_W];
  assign e_ptr       = mem_rsp_data[63 -: AW];

  assign idx      = key >> (KEY_W - int'(size));
  assign mem_addr = base + (AW'(idx) << 5);
  assign kshift   = key << size;
  assign gbits    = kshift >> (KEY_W - int'(e_glen));
  assign gmask    = (KEY_W'(1) << e_glen) - KEY_W'(1);
  assign gmatch   = (e_guard & gmask) == gbits;
  assign used     = CW'(size) + CW'(e_glen);
  assign bad      = !e_valid || !gmatch ||
                    (e_leaf ? (used != rem)
                            : (used >= rem || e_nsize == '0 || depth == DW'(MAX_DEPTH - 1)));

  assign req_ready     = state == S_IDLE;
  assign mem_req_valid = state == S_REQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      key       <= '0;
      rem       <= '0;
      size      <= '0;
      base      <= '0;
      depth     <= '0;
      rsp_done  <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_pfn   <= '0;
    end else begin
      rsp_done <= 1'b0;
      case (state)
        S_IDLE: if (req_valid) begin
          key   <= req_vpn;
          rem   <= CW'(KEY_W);
          size  <= req_root_size;
          base  <= req_root;
          depth <= '0;
          state <= S_REQ;
        end
        S_REQ: if (mem_req_ready) state <= S_WAIT;
        S_WAIT: if (mem_rsp_valid) begin
          if (bad || e_leaf) begin
            rsp_done  <= 1'b1;
            rsp_fault <= bad;
            rsp_pfn   <= bad ? '0 : e_ptr[PFN_W-1:0];
            state     <= S_IDLE;
          end else begin
            key   <= kshift << e_glen;
            rem   <= rem - used;
            size  <= e_nsize;
            base  <= e_ptr;
            depth <= depth + 1'b1;
            state <= S_REQ;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r1_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!req_ready && !rsp_done));
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_addr)));
  a_r9_single: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_ready) |=> !mem_req_valid);
  a_r10_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);
  a_r10_zero_pfn: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && rsp_fault) |-> (rsp_pfn == '0));
  a_r8_depth: assert property (@(posedge clk) disable iff (!rst_n)
    depth < DW'(MAX_DEPTH));
  a_r5_shrink: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_IDLE && $past(state) != S_IDLE) |-> (rem <= $past(rem)));
endmodule

// File: tb/gpt_walker_test.sv
module gpt_walker_test;
  localparam int CLK_P = 10;
  localparam int KW = 10;
  localparam int PW = 20;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_ready;
  logic [KW-1:0] req_vpn = '0;
  logic [31:0] req_root = 32'h0;
  logic [3:0] req_root_size = 4'd1;
  logic rsp_done, rsp_fault;
  logic [PW-1:0] rsp_pfn;
  logic mem_req_valid, mem_req_ready = 0;
  logic [31:0] mem_addr;
  logic mem_rsp_valid = 0;
  logic [63:0] mem_rsp_data = '0;

  gpt_walker #(.KEY_W(KW), .AW(32), .PFN_W(PW), .SZ_W(4), .MAX_DEPTH(3)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vpn(req_vpn), .req_root(req_root), .req_root_size(req_root_size),
    .rsp_done(rsp_done), .rsp_fault(rsp_fault), .rsp_pfn(rsp_pfn),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_addr(mem_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data));

  always #(CLK_P/2) clk = ~clk;

  logic [63:0] mem [0:127];
  int vectors = 0, errors = 0, cycles = 0;
  int nlog = 0;
  logic [31:0] alog [0:7];
  int hold_err = 0;

  function automatic logic [63:0] ent(int leaf, int vld, int glen, int ns, int guard, int ptr);
    logic [31:0] lo;
    lo = 32'((guard << 12) | (ns << 8) | (glen << 3) | (vld << 1) | leaf);
    return {32'(ptr), lo};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory model: variable stall before accept, variable latency after
  int pat = 0, lat = 0;
  bit busy = 0, pend = 0;
  logic [31:0] paddr;
  always @(negedge clk) begin
    pat++;
    if (pend) begin
      if (!(mem_req_valid && mem_addr == paddr)) hold_err++;
      pend = 0;
    end
    if (mem_rsp_valid) mem_rsp_valid = 0;
    if (busy) begin
      if (lat == 0) begin
        mem_rsp_data = mem[mem_addr[11:5]];
        mem_rsp_valid = 1;
        busy = 0;
      end else lat--;
    end else if (mem_req_ready) begin
      mem_req_ready = 0;
      if (nlog < 8) alog[nlog] = mem_addr;
      nlog++;
      busy = 1;
      lat = (pat >> 1) % 4;
    end else if (mem_req_valid) begin
      if (pat % 3 != 0) mem_req_ready = 1;
      else begin pend = 1; paddr = mem_addr; end
    end
  end

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = '0;
    mem[0] = ent(0, 1, 3, 2, 5, 'h400);
    mem[1] = ent(0, 1, 0, 3, 0, 'h800);
    for (int j = 0; j < 3; j++) mem[32 + j] = ent(1, 1, 4, 0, j * 3, 'h100 + j);
    for (int i = 0; i < 5; i++) mem[64 + i] = ent(1, 1, 6, 0, i * 5, 'h200 + i);
    mem[69] = ent(1, 1, 3, 0, 0, 'h2FF);
    mem[70] = ent(0, 1, 0, 1, 0, 'hE00);
    mem[71] = ent(0, 1, 2, 4, 3, 'hC00);
    for (int m = 0; m < 16; m++) mem[96 + m] = ent(1, 1, 0, 0, 0, 'h300 + m);
    mem[112] = ent(0, 1, 0, 1, 0, 'hE00);
    mem[113] = ent(1, 1, 5, 0, 21, 'h3F0);
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++; vectors++;
        $display("FAIL watchdog actual=%0d expected<150000", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 ready", 32'(req_ready), 1);
    check("R1 done", 32'(rsp_done), 0);
    check("R9 idle memreq", 32'(mem_req_valid), 0);
    rst_n = 1;
    @(negedge clk);
    for (int k = 0; k < 1024; k++) begin
      bit ef; int ep; string tag; int ea2; bit has2;
      int i, j;
      i = (k >> 6) & 7; j = (k >> 4) & 3;
      ef = 1; ep = 0; tag = "R4"; has2 = 0; ea2 = 0;
      if ((k >> 9) == 0) begin
        if (i == 5) begin
          has2 = 1; ea2 = 'h400 + j * 32;
          if (j == 3) tag = "R7";
          else if ((k & 15) == j * 3) begin ef = 0; ep = 'h100 + j; tag = "R6"; end
        end
      end else begin
        has2 = 1; ea2 = 'h800 + i * 32;
        if (i <= 4) begin
          if ((k & 63) == i * 5) begin ef = 0; ep = 'h200 + i; tag = "R6"; end
        end else if (i == 5) tag = "R5";
        else if (i == 6) begin
          if (((k >> 5) & 1) == 0) tag = "R8";
          else if ((k & 31) == 21) begin ef = 0; ep = 'h3F0; tag = "R6"; end
        end else begin
          if (j == 3) begin ef = 0; ep = 'h300 + (k & 15); tag = "R6"; end
        end
      end
      while (!req_ready) @(negedge clk);
      nlog = 0;
      req_vpn = KW'(k);
      req_valid = 1;
      @(negedge clk);
      req_valid = 0;
      if (k == 0) check("R1 busy", 32'(req_ready), 0);
      while (!rsp_done) @(negedge clk);
      check({tag, " fault"}, 32'(rsp_fault), 32'(ef));
      check({tag, " pfn"}, 32'(rsp_pfn), 32'(ep));
      check("R2 first addr", alog[0], 32'((k >> 9) * 32));
      if (has2) check("R3 second addr", alog[1], 32'(ea2));
      @(negedge clk);
      check("R10 pulse", 32'(rsp_done), 0);
    end
    check("R9 hold", 32'(hold_err), 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule